// File: doc/BRIEF.md
# Pruned Multistage CIC Decimator

This block reduces the sample rate of a digital receiver's signed 16-bit stream by a fixed factor of 1000. Five cascaded integrators run at the input rate and advance only on accepted samples. A down-sample counter picks every thousandth accepted sample. Five comb sections with a differential delay of one then run at the low rate, one section per clock. The result is a signed 16-bit sample marked by a single-cycle valid pulse.

The full-precision datapath is 66 bits wide. That is the input width plus five times the ceiling of log2 of the rate, so the wrap-around arithmetic in the integrators cancels exactly in the combs. Two build-time options are available:

- **Word width:** either every stage keeps all 66 bits and the output takes the top 16 bits, or every stage discards the same number of low-order bits so the chain narrows steadily towards the output.
- **Adder:** each stage adds either with a plain two's-complement adder or with a 3:2 carry-save compressor whose redundant pair is resolved at the stage output.

Top module: `cic_decim`

## Requirements
- R1: A synchronous active-high reset clears the integrators, the comb delay registers, the down-sample counter and the strobe pipeline, and drives `out_valid` and `out_data` to 0.
- R2: A sample is accepted only on a clock edge where `in_valid` is 1. Exactly one output is produced per 1000 accepted samples, and no output is produced otherwise. Cycles with `in_valid` at 0 leave the filter state unchanged.
- R3: `out_valid` is a one-clock pulse. It is high in the cycle after the 6th rising edge (comb stages + 1) that follows the edge accepting the 1000th sample of a window.
- R4: In final-only pruning mode, `out_data` is bits [65:50] of the 66-bit fifth comb output. Integrator 0 adds the sign-extended input, and each later integrator adds the registered value of the integrator before it. Each comb subtracts its previous low-rate input from its current one.
- R5: The integrators wrap modulo 2^66 with no saturation. Sustained full-scale inputs (+32767, or -32768) still give the exact modular result of R4.
- R6: The comb delay registers start at zero after reset, so the first output after a reset is the comb chain's response to one window with zero history.
- R7: In per-stage pruning mode, the ten stages are numbered 0 to 9 with the integrators first, and stage k is 66-5k bits wide. Every stage except stage 0 takes its predecessor's output shifted arithmetically right by 5 bits. `out_data` is the 21-bit last comb output shifted arithmetically right by 5 bits.
- R8: The carry-save adder style gives outputs bit-identical to the plain adder style for the same input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is accepted on this edge |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new output sample |
| out_data | output | 16 | Signed decimated sample |

## Verification
A corrupted integrator value disturbs every later window. Because the five combs annihilate any polynomial of degree below five, the error shows in `out_data` within the next one to five outputs and then disappears, so every output is compared against an exact model. A counter fault shows at once as an `out_valid` pulse in the wrong cycle or a window of the wrong length, so the arrival cycle of every pulse is checked as well. A pruning or adder-style fault shows as a value mismatch on the first output of the affected build.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    localparam int IN_W   = 16;
    localparam int OUT_W  = 16;
    localparam int STAGES = 5;
    localparam int RATE   = 1000;

    typedef enum logic {ADD_RIPPLE, ADD_CSA} adder_e;
    typedef enum logic {PRUNE_FINAL, PRUNE_STAGE} prune_e;

    // Growth-safe internal width: input bits plus STAGES * ceil(log2(rate))
    function automatic int full_width(int in_w, int stages, int rate);
        return in_w + stages * $clog2(rate);
    endfunction

    // LSBs discarded at the entry of each stage after the first
    function automatic int drop_per_stage(prune_e mode, int full_w, int out_w, int stages);
        return (mode == PRUNE_STAGE) ? (full_w - out_w) / (2 * stages) : 0;
    endfunction

    // Width of stage idx (0..2*stages-1, integrators first)
    function automatic int stage_width(int full_w, int drop, int idx);
        return full_w - drop * idx;
    endfunction

endpackage

// File: rtl/cic_adder.sv
`timescale 1ns/1ps
module cic_adder
    import cic_pkg::*;
#(
    parameter int     W     = 8,
    parameter adder_e STYLE = ADD_RIPPLE,
    parameter bit     SUB   = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] bb;
    logic [W-1:0] cv;

    assign bb = SUB ? ~b : b;
    assign cv = SUB ? W'(1) : '0;

    generate
        if (STYLE == ADD_CSA) begin : g_csa
            logic [W-1:0] ps;
            logic [W-1:0] pc;
            assign ps  = a ^ bb ^ cv;
            assign pc  = ((a & bb) | (a & cv) | (bb & cv)) << 1;
            assign sum = ps + pc;
        end else begin : g_ripple
            assign sum = a + bb + cv;
        end
    endgenerate
endmodule

// File: rtl/cic_integ_stage.sv
`timescale 1ns/1ps
module cic_integ_stage
    import cic_pkg::*;
#(
    parameter int     W     = 66,
    parameter adder_e STYLE = ADD_RIPPLE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] acc
);
    logic [W-1:0] nxt;

    cic_adder #(.W(W), .STYLE(STYLE), .SUB(1'b0)) u_add (
        .a   (acc),
        .b   (din),
        .sum (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= nxt;
    end

    AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc)); // R2
    AST_INTEG_SUM: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == W'($past(acc) + $past(din))); // R8
endmodule

// File: rtl/cic_comb_stage.sv
`timescale 1ns/1ps
module cic_comb_stage
    import cic_pkg::*;
#(
    parameter int     W     = 66,
    parameter adder_e STYLE = ADD_RIPPLE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] dly;
    logic [W-1:0]        diff;

    cic_adder #(.W(W), .STYLE(STYLE), .SUB(1'b1)) u_sub (
        .a   (din),
        .b   (dly),
        .sum (diff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dly  <= '0;
            dout <= '0;
        end else if (en) begin
            dly  <= din;
            dout <= diff;
        end
    end

    AST_COMB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout) && $stable(dly)); // R6
    AST_COMB_DIFF: assert property (@(posedge clk) disable iff (rst)
        en |=> dout == W'($past(din) - $past(dly))); // R4
endmodule

// File: rtl/cic_rate_ctrl.sv
`timescale 1ns/1ps
module cic_rate_ctrl #(
    parameter int RATE   = 1000,
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic [STAGES-1:0] comb_en,
    output logic              out_load
);
    localparam int CNT_W = $clog2(RATE);

    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic [STAGES:0]  sv;

    assign hit = in_valid && (cnt == CNT_W'(RATE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sv  <= '0;
        end else begin
            if (in_valid) cnt <= hit ? '0 : cnt + 1'b1;
            sv <= {sv[STAGES-1:0], hit};
        end
    end

    assign comb_en  = sv[STAGES-1:0];
    assign out_load = sv[STAGES];

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(RATE - 1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt)); // R2
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sv)); // R3
endmodule

// File: rtl/cic_decim.sv
`timescale 1ns/1ps
module cic_decim
    import cic_pkg::*;
#(
    parameter int     IN_W   = cic_pkg::IN_W,
    parameter int     OUT_W  = cic_pkg::OUT_W,
    parameter int     STAGES = cic_pkg::STAGES,
    parameter int     RATE   = cic_pkg::RATE,
    parameter prune_e PRUNE  = PRUNE_FINAL,
    parameter adder_e ADDER  = ADD_RIPPLE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int FULL_W     = full_width(IN_W, STAGES, RATE);
    localparam int DROP       = drop_per_stage(PRUNE, FULL_W, OUT_W, STAGES);
    localparam int LAST_W     = stage_width(FULL_W, DROP, 2 * STAGES - 1);
    localparam int FINAL_DROP = LAST_W - OUT_W;

    // Stage results, sign-extended to the full width
    logic [STAGES-1:0][FULL_W-1:0] ibus;
    logic [STAGES-1:0][FULL_W-1:0] cbus;
    logic [STAGES-1:0]             comb_en;
    logic                          out_load;

    cic_rate_ctrl #(.RATE(RATE), .STAGES(STAGES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .comb_en  (comb_en),
        .out_load (out_load)
    );

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_integ
            localparam int WI = stage_width(FULL_W, DROP, i);
            logic signed [WI-1:0] din;
            logic signed [WI-1:0] acc;
            if (i == 0) begin : g_first
                assign din = WI'(in_data);
            end else begin : g_next
                assign din = WI'($signed(ibus[i-1]) >>> DROP);
            end
            cic_integ_stage #(.W(WI), .STYLE(ADDER)) u_integ (
                .clk (clk),
                .rst (rst),
                .en  (in_valid),
                .din (din),
                .acc (acc)
            );
            assign ibus[i] = FULL_W'(acc);
        end

        for (genvar j = 0; j < STAGES; j++) begin : g_comb
            localparam int WC = stage_width(FULL_W, DROP, STAGES + j);
            logic signed [WC-1:0] din;
            logic signed [WC-1:0] dout;
            if (j == 0) begin : g_first
                assign din = WC'($signed(ibus[STAGES-1]) >>> DROP);
            end else begin : g_next
                assign din = WC'($signed(cbus[j-1]) >>> DROP);
            end
            cic_comb_stage #(.W(WC), .STYLE(ADDER)) u_comb (
                .clk  (clk),
                .rst  (rst),
                .en   (comb_en[j]),
                .din  (din),
                .dout (dout)
            );
            assign cbus[j] = FULL_W'(dout);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= out_load;
            if (out_load) out_data <= OUT_W'($signed(cbus[STAGES-1]) >>> FINAL_DROP);
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R3
    AST_DATA_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data)); // R2
endmodule

// File: tb/cic_decim_bench.sv
`timescale 1ns/1ps
module cic_decim_bench;
    import cic_pkg::*;

    localparam int NS  = 5;
    localparam int RT  = 1000;
    localparam int FW  = 66;
    localparam int LAT = NS + 1;

    typedef struct {
        logic signed [15:0] d;
        int                 c;
        string              tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic [2:0]         ov;
    logic signed [15:0] od [3];

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R4";

    logic signed [FW-1:0] mi [2][NS];
    logic signed [FW-1:0] md [2][NS];
    int                   mcnt;
    exp_t                 q0[$];
    exp_t                 q1[$];
    exp_t                 q2[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cic_decim #(.PRUNE(PRUNE_FINAL), .ADDER(ADD_RIPPLE)) u_cic_decim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[0]), .out_data(od[0]));
    cic_decim #(.PRUNE(PRUNE_FINAL), .ADDER(ADD_CSA)) u_cic_decim_csa (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[1]), .out_data(od[1]));
    cic_decim #(.PRUNE(PRUNE_STAGE), .ADDER(ADD_RIPPLE)) u_cic_decim_prn (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[2]), .out_data(od[2]));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic signed [FW-1:0] sx(input logic signed [FW-1:0] v, input int w);
        logic signed [FW-1:0] t;
        t = v <<< (FW - w);
        return t >>> (FW - w);
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < NS; i++) begin
                mi[p][i] = '0;
                md[p][i] = '0;
            end
        mcnt = 0;
    endtask

    // Exact model of R4 (p=0, no pruning) and R7 (p=1, 5 LSBs per stage)
    task automatic model_push(input logic signed [15:0] x, input int hitc);
        logic signed [FW-1:0] old [NS];
        logic signed [FW-1:0] inp, v, t;
        int   drop, w;
        exp_t e;
        for (int p = 0; p < 2; p++) begin
            drop = (p == 1) ? 5 : 0;
            for (int i = 0; i < NS; i++) old[i] = mi[p][i];
            for (int i = 0; i < NS; i++) begin
                inp = (i == 0) ? FW'(x) : (old[i-1] >>> drop);
                mi[p][i] = sx(old[i] + inp, FW - drop * i);
            end
        end
        mcnt++;
        if (mcnt == RT) begin
            mcnt = 0;
            for (int p = 0; p < 2; p++) begin
                drop = (p == 1) ? 5 : 0;
                v = mi[p][NS-1];
                w = FW;
                for (int j = 0; j < NS; j++) begin
                    w   = FW - drop * (NS + j);
                    inp = sx(v >>> drop, w);
                    t   = sx(inp - md[p][j], w);
                    md[p][j] = inp;
                    v = t;
                end
                e.d = 16'(v >>> (w - 16));
                e.c = hitc + LAT;
                if (p == 0) begin
                    e.tag = cur_tag;
                    q0.push_back(e);
                    e.tag = "R8";
                    q1.push_back(e);
                end else begin
                    e.tag = "R7";
                    q2.push_back(e);
                end
            end
        end
    endtask

    task automatic send(input bit v, input logic signed [15:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        if (v) model_push(d, cyc + 1);
    endtask

    task automatic run_const(input logic signed [15:0] d, input int n);
        for (int k = 0; k < n; k++) send(1'b1, d);
    endtask

    // n accepted samples with roughly dens percent valid cycles
    task automatic run_rand(input int n, input int dens);
        int acc = 0;
        while (acc < n) begin
            if (($urandom % 100) < dens) begin
                send(1'b1, 16'($urandom));
                acc++;
            end else begin
                send(1'b0, 16'($urandom));
            end
        end
    endtask

    task automatic check_port(input int k, input logic v, input logic signed [15:0] d);
        exp_t e;
        bit   have;
        have = (k == 0) ? (q0.size() > 0) : (k == 1) ? (q1.size() > 0) : (q2.size() > 0);
        if (have) begin
            e = (k == 0) ? q0[0] : (k == 1) ? q1[0] : q2[0];
            if (e.c < cyc) begin
                chk(1'b0, "R3 missing out_valid pulse", 0, e.c);
                if (k == 0) void'(q0.pop_front());
                else if (k == 1) void'(q1.pop_front());
                else void'(q2.pop_front());
                return;
            end
        end
        if (!v) return;
        if (!have) begin
            chk(1'b0, "R2 unexpected out_valid", 1, 0);
            return;
        end
        if (k == 0) void'(q0.pop_front());
        else if (k == 1) void'(q1.pop_front());
        else void'(q2.pop_front());
        chk(cyc == e.c, "R3 out_valid cycle", cyc, e.c);
        chk(d == e.d, e.tag, int'(d), int'(e.d));
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check_port(0, ov[0], od[0]);
            check_port(1, ov[1], od[1]);
            check_port(2, ov[2], od[2]);
        end
    end

    task automatic check_reset_state();
        for (int k = 0; k < 3; k++) begin
            chk(ov[k] == 1'b0, "R1 out_valid after reset", int'(ov[k]), 0);
            chk(od[k] == 16'sd0, "R1 out_data after reset", int'(od[k]), 0);
        end
    endtask

    task automatic check_drained();
        chk(q0.size() == 0, "R2 outputs pending (plain)", q0.size(), 0);
        chk(q1.size() == 0, "R2 outputs pending (carry-save)", q1.size(), 0);
        chk(q2.size() == 0, "R2 outputs pending (pruned)", q2.size(), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c1c0));
        model_reset();
        repeat (4) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        cur_tag = "R4";
        run_const(16'sd0, 1000);
        cur_tag = "R5";                       // r5_ sustained full scale, wrap cancels
        run_const(16'sd32767, 5000);
        run_const(-16'sd32768, 5000);
        cur_tag = "R2";                       // gaps in in_valid must not count
        run_rand(8000, 60);
        cur_tag = "R5";
        for (int k = 0; k < 1000; k++) begin
            send(1'b1, 16'sd32767);
            send(1'b1, -16'sd32768);
        end
        cur_tag = "R4";
        run_rand(3000, 100);
        repeat (20) send(1'b0, 16'sd0);
        check_drained();

        // Partial window, then reset: R1 clears, R6 fresh comb history
        run_rand(437, 100);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        model_reset();
        q0.delete();
        q1.delete();
        q2.delete();
        rst = 1'b0;
        cur_tag = "R6";
        run_rand(2000, 100);
        repeat (20) send(1'b0, 16'sd0);
        check_drained();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule